// File: doc/BRIEF.md
# Serial Clock-Chip Command Engine

This block sits behind one byte of a host control register and acts as the clock-chip end of a bit-banged serial link. Software writes the byte repeatedly. One bit enables the link, one bit is a clock line driven by the host, and one bit carries data in both directions. Each high-to-low change of the clock line, seen between two successive host writes while the link is enabled, moves the transfer one step forward. The first eight steps assemble a command byte, most significant bit first. The next eight steps assemble a value byte in the same way.

When the command names a readable byte, the engine overwrites the data bit of the stored control byte on each of those eight later steps. It takes the bits of the chosen byte in order, most significant first, so software reads the bit back before its next write. The readable bytes are a small scratch RAM, a fixed status byte and a control byte supplied from outside. When the command is a RAM write, the assembled value lands in RAM on the sixteenth step. Dropping the enable bit abandons the transfer at any point.

Top module: `rtc_serial_engine`

## Requirements
- R1: After reset the link byte reads 0x0C, every RAM entry reads 0x00 and the engine is idle.
- R2: A host write with bit 0 (enable) clear abandons any transfer. The step count, command and value are cleared, no RAM entry changes, and the next enabled transfer starts again from step 0.
- R3: A step is taken only when bit 1 (clock) was 1 in the previously stored byte and is 0 in the new host write while enable is set. Rising edges and writes that leave the clock unchanged take no step.
- R4: Steps 0 to 7 shift bit 2 (data) into the command, most significant bit first.
- R5: For commands 0x00 to 0x1F, the falling edges of steps 8 to 15 replace bit 2 of the link byte with bit (15 − step) of the RAM entry at the command's index.
- R6: Command 0x30 returns the status byte 0x90 the same way.
- R7: Command 0x31 returns the `ctrl_byte` input the same way.
- R8: For commands 0x80 to 0x9F, the 16th falling edge stores the eight data bits of steps 8 to 15 into RAM entry (command − 0x80).
- R9: After the 16th step, further falling edges are ignored until enable drops. They cause no RAM write and no replacement of bit 2.
- R10: For any command that selects no readable byte, bit 2 keeps the host's written value. Bits 7:3 and 1:0 of the link byte always equal the last host write.
- R11: Without a host write the link byte holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host writes the link byte this cycle |
| host_byte | input | 8 | Byte written by the host (bit 0 enable, bit 1 clock, bit 2 data) |
| ctrl_byte | input | 8 | Byte returned by command 0x31 |
| link_byte | output | 8 | Stored link byte, with bit 2 carrying read data |

## Verification
The bench builds the engine with its default values: a 32-entry RAM, status 0x90 and link reset 0x0C. At these values the whole read range 0x00–0x1F and the whole write range 0x80–0x9F can be hit, including both boundary indices, along with the status and control commands placed just beyond the RAM. Random transfers and directed ones are mixed. The directed transfers cover a transfer cut short, extra edges past the 16th, and writes between edges that leave the clock unchanged.

// File: rtl/rtc_link_pkg.sv
package rtc_link_pkg;

    localparam int EN_BIT  = 0;
    localparam int CLK_BIT = 1;
    localparam int DAT_BIT = 2;

    localparam int          CMD_BITS    = 8;
    localparam int          VAL_BITS    = 8;
    localparam logic [4:0]  LAST_STEP   = 5'(CMD_BITS + VAL_BITS);
    localparam logic [7:0]  CMD_STATUS  = 8'h30;
    localparam logic [7:0]  CMD_CONTROL = 8'h31;
    localparam logic [7:0]  WR_BASE     = 8'h80;

    typedef struct packed {
        logic       active;
        logic [4:0] step;
        logic [7:0] cmd;
        logic [7:0] val;
        logic [7:0] link;
    } seq_state_t;

endpackage

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rtc_read_select.sv
module rtc_read_select
    import rtc_link_pkg::*;
#(
    parameter int         DEPTH      = 32,
    parameter logic [7:0] STATUS_VAL = 8'h90
) (
    input  logic [7:0] cmd,
    input  logic [7:0] ram_byte,
    input  logic [7:0] ctrl_byte,
    output logic [7:0] sel_byte,
    output logic       sel_valid
);

    localparam logic [7:0] RAM_END = 8'(DEPTH);

    always_comb begin
        sel_valid = 1'b0;
        sel_byte  = '0;
        if (cmd < RAM_END) begin
            sel_valid = 1'b1;
            sel_byte  = ram_byte;
        end else if (cmd == CMD_STATUS) begin
            sel_valid = 1'b1;
            sel_byte  = STATUS_VAL;
        end else if (cmd == CMD_CONTROL) begin
            sel_valid = 1'b1;
            sel_byte  = ctrl_byte;
        end
    end

endmodule

// File: rtl/rtc_link_seq.sv
module rtc_link_seq
    import rtc_link_pkg::*;
#(
    parameter int         DEPTH      = 32,
    parameter logic [7:0] LINK_RESET = 8'h0C,
    localparam int        AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [7:0]    host_byte,
    input  logic [7:0]    sel_byte,
    input  logic          sel_valid,
    output logic [7:0]    link_byte,
    output logic [7:0]    cmd_q,
    output logic [4:0]    step_q,
    output logic          active_q,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);

    localparam logic [7:0] WR_END = WR_BASE + 8'(DEPTH);

    seq_state_t s_q, s_d;
    logic       falling;
    logic       in_wr_range;
    logic [4:0] cur;

    assign falling     = s_q.link[CLK_BIT] & ~host_byte[CLK_BIT];
    assign in_wr_range = (s_q.cmd >= WR_BASE) && (s_q.cmd < WR_END);
    assign cur         = s_q.active ? s_q.step : 5'd0;

    always_comb begin
        s_d   = s_q;
        wr_en = 1'b0;
        if (host_we) begin
            s_d.link = host_byte;
            if (!host_byte[EN_BIT]) begin
                s_d.active = 1'b0;
                s_d.step   = '0;
                s_d.cmd    = '0;
                s_d.val    = '0;
            end else begin
                s_d.active = 1'b1;
                s_d.step   = cur;
                if (falling && cur != LAST_STEP) begin
                    if (cur < 5'(CMD_BITS)) begin
                        s_d.cmd = {s_q.cmd[6:0], host_byte[DAT_BIT]};
                    end else begin
                        s_d.val = {s_q.val[6:0], host_byte[DAT_BIT]};
                        if (sel_valid) begin
                            s_d.link[DAT_BIT] = sel_byte[~cur[2:0]];
                        end
                    end
                    s_d.step = cur + 5'd1;
                    if (cur == LAST_STEP - 5'd1 && in_wr_range) begin
                        wr_en = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{active: 1'b0, step: '0, cmd: '0, val: '0, link: LINK_RESET};
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_addr   = s_q.cmd[AW-1:0];
    assign wr_data   = s_d.val;
    assign link_byte = s_q.link;
    assign cmd_q     = s_q.cmd;
    assign step_q    = s_q.step;
    assign active_q  = s_q.active;

endmodule

// File: rtl/rtc_serial_engine.sv
module rtc_serial_engine #(
    parameter int         RAM_DEPTH  = 32,
    parameter logic [7:0] STATUS_VAL = 8'h90,
    parameter logic [7:0] LINK_RESET = 8'h0C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_we,
    input  logic [7:0] host_byte,
    input  logic [7:0] ctrl_byte,
    output logic [7:0] link_byte
);

    localparam int AW = $clog2(RAM_DEPTH);

    logic [7:0]    cmd_w;
    logic [4:0]    step_w;
    logic          active_w;
    logic          wr_en_w;
    logic [AW-1:0] wr_addr_w;
    logic [7:0]    wr_data_w;
    logic [7:0]    ram_byte_w;
    logic [7:0]    sel_byte_w;
    logic          sel_valid_w;

    rtc_link_seq #(
        .DEPTH      (RAM_DEPTH),
        .LINK_RESET (LINK_RESET)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_byte (host_byte),
        .sel_byte  (sel_byte_w),
        .sel_valid (sel_valid_w),
        .link_byte (link_byte),
        .cmd_q     (cmd_w),
        .step_q    (step_w),
        .active_q  (active_w),
        .wr_en     (wr_en_w),
        .wr_addr   (wr_addr_w),
        .wr_data   (wr_data_w)
    );

    rtc_byte_store #(
        .DEPTH (RAM_DEPTH)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en_w),
        .waddr (wr_addr_w),
        .wdata (wr_data_w),
        .raddr (cmd_w[AW-1:0]),
        .rdata (ram_byte_w)
    );

    rtc_read_select #(
        .DEPTH      (RAM_DEPTH),
        .STATUS_VAL (STATUS_VAL)
    ) i_sel (
        .cmd       (cmd_w),
        .ram_byte  (ram_byte_w),
        .ctrl_byte (ctrl_byte),
        .sel_byte  (sel_byte_w),
        .sel_valid (sel_valid_w)
    );

endmodule

// File: rtl/rtc_link_chk.sv
module rtc_link_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_we,
    input logic [7:0] host_byte,
    input logic [7:0] link_byte,
    input logic       active_q,
    input logic [4:0] step_q,
    input logic [7:0] cmd_q,
    input logic       wr_en
);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |=> $stable(link_byte));

    // R2
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !host_byte[0]) |=> (!active_q && step_q == 5'd0 && cmd_q == 8'h00));

    // R9
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= 5'd16);

    // R3
    no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_byte[0] && active_q && !(link_byte[1] && !host_byte[1]))
        |=> $stable(step_q));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_byte[0] && active_q)
        |=> (step_q == $past(step_q) || step_q == $past(step_q) + 5'd1));

    // R10
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> (link_byte[7:3] == $past(host_byte[7:3]) &&
                     link_byte[1:0] == $past(host_byte[1:0])));

    // R8
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (active_q && step_q == 5'd16));

endmodule

bind rtc_serial_engine rtc_link_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_byte (host_byte),
    .link_byte (link_byte),
    .active_q  (active_w),
    .step_q    (step_w),
    .cmd_q     (cmd_w),
    .wr_en     (wr_en_w)
);

// File: tb/test_rtc_serial_engine.sv
`timescale 1ns/1ps
module test_rtc_serial_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [7:0] host_byte = 8'h00;
    logic [7:0] ctrl_byte = 8'h00;
    logic [7:0] link_byte;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] shadow [32];

    always #2.5 clk = ~clk;

    rtc_serial_engine i_rtc_serial_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_byte (host_byte),
        .ctrl_byte (ctrl_byte),
        .link_byte (link_byte)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one host write; sampled at the following falling clock edge
    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        host_we   = 1'b1;
        host_byte = b;
        @(negedge clk);
        host_we   = 1'b0;
        check("R10 side bits", link_byte & 8'hFB, b & 8'hFB);
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] cmd, input logic [7:0] val);
        if (cmd < 8'h20)       return shadow[cmd[4:0]];
        else if (cmd == 8'h30) return 8'h90;
        else if (cmd == 8'h31) return ctrl_byte;
        else                   return val;
    endfunction

    // full or partial transfer; noise adds writes without a falling edge
    task automatic xfer(input logic [7:0] cmd, input logic [7:0] val, input int edges,
                        input bit noise, output logic [7:0] got, output logic [7:0] tail);
        logic [7:0] hi;
        hi   = 8'($urandom) & 8'hF8;
        got  = '0;
        tail = '0;
        wr(hi | 8'h03);
        for (int i = 0; i < edges; i++) begin
            logic b;
            b = (i < 8) ? cmd[7-i] : ((i < 16) ? val[15-i] : 1'b1);
            if (noise) wr(hi | 8'h03 | {5'd0, ~b, 2'b00});
            wr(hi | 8'h03 | {5'd0, b, 2'b00});
            wr(hi | 8'h01 | {5'd0, b, 2'b00});
            if (i >= 8 && i < 16) got = {got[6:0], link_byte[2]};
            else if (i >= 16)     tail = {tail[6:0], link_byte[2]};
            if (noise) wr(hi | 8'h01 | {5'd0, ~b, 2'b00});
        end
        wr(hi);
        if (edges >= 16 && cmd >= 8'h80 && cmd < 8'hA0) shadow[cmd[4:0]] = val;
    endtask

    initial begin
        logic [7:0] got, tail, hold;
        void'($urandom(32'd24681357));
        for (int i = 0; i < 32; i++) shadow[i] = 8'h00;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset link", link_byte, 8'h0C);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset link after release", link_byte, 8'h0C);
        xfer(8'h1F, 8'h00, 16, 0, got, tail);
        check("R1 ram cleared idx 31", got, 8'h00);

        // R6 status, R7 control
        xfer(8'h30, 8'h00, 16, 0, got, tail);
        check("R6 status", got, 8'h90);
        ctrl_byte = 8'hA5;
        xfer(8'h31, 8'h00, 16, 0, got, tail);
        check("R7 control", got, 8'hA5);

        // R8 boundary writes, R5 readback
        xfer(8'h80, 8'h3C, 16, 0, got, tail);
        xfer(8'h9F, 8'hC3, 16, 0, got, tail);
        xfer(8'h00, 8'h00, 16, 0, got, tail);
        check("R5 R8 idx 0", got, 8'h3C);
        xfer(8'h1F, 8'h00, 16, 0, got, tail);
        check("R5 R8 idx 31", got, 8'hC3);

        // R3 writes without falling edges take no step
        xfer(8'h1F, 8'h00, 16, 1, got, tail);
        check("R3 noisy read", got, 8'hC3);
        xfer(8'h85, 8'h96, 16, 1, got, tail);
        xfer(8'h05, 8'h00, 16, 0, got, tail);
        check("R3 R4 noisy write", got, 8'h96);

        // R2 abort before the 16th edge
        xfer(8'h85, 8'h11, 15, 0, got, tail);
        xfer(8'h05, 8'h00, 16, 0, got, tail);
        check("R2 aborted write", got, 8'h96);
        xfer(8'h31, 8'h00, 5, 0, got, tail);
        xfer(8'h30, 8'h00, 16, 0, got, tail);
        check("R2 restart after abort", got, 8'h90);

        // R9 extra edges ignored
        xfer(8'h30, 8'h00, 24, 0, got, tail);
        check("R9 read tail not replaced", tail, 8'hFF);
        xfer(8'h86, 8'h5A, 24, 0, got, tail);
        xfer(8'h06, 8'h00, 16, 0, got, tail);
        check("R9 R8 tail no rewrite", got, 8'h5A);

        // R10 non-readable command returns host bits
        xfer(8'h40, 8'h69, 16, 0, got, tail);
        check("R10 other cmd", got, 8'h69);
        xfer(8'h88, 8'hE7, 16, 0, got, tail);
        check("R10 write cmd echoes", got, 8'hE7);

        // R11 hold without writes
        hold = link_byte;
        repeat (6) @(negedge clk);
        check("R11 hold", link_byte, hold);

        // random mix
        for (int n = 0; n < 120; n++) begin
            logic [7:0] c, v;
            int kind;
            kind = int'($urandom % 4);
            v = 8'($urandom);
            case (kind)
                0: c = 8'h80 | {3'd0, 5'($urandom)};
                1: c = {3'd0, 5'($urandom)};
                2: begin c = ($urandom % 2 == 0) ? 8'h30 : 8'h31; ctrl_byte = 8'($urandom); end
                default: begin
                    c = 8'($urandom);
                    if (c < 8'h20 || c == 8'h30 || c == 8'h31 || (c >= 8'h80 && c < 8'hA0)) c = 8'h55;
                end
            endcase
            xfer(c, v, 16, ($urandom % 4 == 0), got, tail);
            if (kind == 0) check("R8 random write echo", got, v);
            else if (kind == 1) check("R5 random read", got, exp_read(c, v));
            else if (kind == 2) check("R6 R7 random status/control", got, exp_read(c, v));
            else check("R10 random other", got, v);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule